// File: doc/BRIEF.md
# Dual Reference Divider to an 8 kHz Comparison Rate

This block takes two reference clock signals, samples each in the system clock domain, and divides each one down to an 8 kHz strobe train for a downstream phase detector. Comparing phase at 8 kHz rather than at the raw reference rate gives the loop more room to absorb input jitter. Each reference has its own 8-bit mode byte that selects manual division by a shared programmable factor, division by a built-in factor for one of a few common line rates, or no division at all.

One 14-bit value N is shared by both references, and the manual divide factor is N+1. Writes of N outside the legal range are refused and flagged. A single polarity input decides whether the rising or the falling transition of the references is counted and marks each output strobe. Divisor changes never shorten or stretch a period that is already under way.

Top module: `refdiv_8k`

## Requirements
- R1: When mode bit 7 is set, a reference produces one strobe for every N+1 counted transitions, and both references use the same N.
- R2: A write of N is accepted only if 1 <= N <= 12499. Any other value leaves N unchanged and sets `n_err`, which stays set until reset. A later legal write is still accepted.
- R3: When mode bit 6 is set and bit 7 is clear, the divisor comes from bits 3:0 of the mode byte: code 1 gives 193, code 2 gives 256, code 3 gives 810, and code 4 gives 2430.
- R4: When neither bit 7 nor bit 6 is set, or bit 6 is set with a code other than 1 to 4, every counted transition produces a strobe.
- R5: Bit 7 takes priority over bit 6. Bits 5:4 of the mode byte have no effect on the output.
- R6: When `fall_edge` is 0, rising transitions are counted; when it is 1, falling transitions are counted. Each strobe lasts one `clk` cycle and rises at the third `clk` edge that samples the counted transition, so the reference is still at its post-transition level while the strobe is high.
- R7: A divisor is captured at the first counted transition of a period and held until that period's final transition. A change of N or mode in mid-period takes effect only from the next period.
- R8: Reset clears all counters and strobes, clears `n_err`, and sets N to 249. The first strobe after reset comes on the divisor-th counted transition.
- R9: The two references count and divide independently of each other, each under its own mode byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the references |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 2 | Reference signals, one bit per reference |
| mode_in | input | 2x8 | Mode byte for each reference (bit 7 manual, bit 6 spot rate, 5:4 ignored, 3:0 rate code) |
| n_wr | input | 1 | Write strobe for the shared N value |
| n_wdata | input | 14 | N value to write |
| fall_edge | input | 1 | 0 counts rising transitions, 1 counts falling transitions |
| tick_8k | output | 2 | One-cycle output strobe for each reference |
| n_err | output | 1 | Sticky flag for a refused N write |

## Verification
The hardest case to reach from the ports is a divisor change that lands part-way through a period. To produce it, the stimulus writes a new N after a few counted transitions. It then checks that no strobe appears before the old count completes, and that the new spacing starts only after that. The spot-rate divisors are run for a full period with a few transitions to spare. Small values of N are swept under both polarities. At every strobe, the reference level is compared with the selected polarity.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
package refdiv_pkg;
    localparam int DIV_W = 14;
    localparam int N_LO  = 1;
    localparam int N_HI  = 12499;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic       manual;
        logic       spot;
        logic [1:0] bucket;
        logic [3:0] code;
    } mode_t;

    function automatic div_t spot_lookup(input logic [3:0] code);
        case (code)
            4'd1:    return div_t'(193);
            4'd2:    return div_t'(256);
            4'd3:    return div_t'(810);
            4'd4:    return div_t'(2430);
            default: return div_t'(1);
        endcase
    endfunction

    function automatic div_t pick_div(input mode_t m, input div_t n);
        if (m.manual)    return n + div_t'(1);
        else if (m.spot) return spot_lookup(m.code);
        else             return div_t'(1);
    endfunction

    function automatic logic n_legal(input div_t n);
        return (n >= div_t'(N_LO)) && (n <= div_t'(N_HI));
    endfunction
endpackage

// File: rtl/refdiv_edge.sv
`timescale 1ns/1ps
module refdiv_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    input  logic fall_sel,
    output logic evt_o
);
    logic [SYNC-1:0] sh;
    logic            prev;
    logic            lvl;

    assign lvl = sh[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[SYNC-2:0], ref_i};
            prev <= lvl;
        end
    end

    assign evt_o = fall_sel ? (prev & ~lvl) : (lvl & ~prev);
endmodule

// File: rtl/refdiv_chan.sv
`timescale 1ns/1ps
module refdiv_chan
    import refdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  div_t div_req_i,
    output logic tick_o
);
    div_t cnt;
    div_t div_act;
    div_t div_eff;
    logic term;

    // while no transition of the period has been counted, the request applies directly
    assign div_eff = (cnt == '0) ? div_req_i : div_act;
    assign term    = (cnt == div_eff - div_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_act <= div_t'(1);
            tick_o  <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (cnt == '0) div_act <= div_req_i;
            if (evt_i) begin
                if (term) begin
                    cnt    <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt <= cnt + div_t'(1);
                end
            end
        end
    end

    p_tick_after_edge_r6: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(evt_i));

    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt < div_eff);

    p_bypass_every_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_i && div_eff == div_t'(1)) |=> tick_o);

    p_no_tick_midperiod_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_i && cnt == '0 && div_req_i > div_t'(1)) |=> !tick_o);
endmodule

// File: rtl/refdiv_nreg.sv
`timescale 1ns/1ps
module refdiv_nreg
    import refdiv_pkg::*;
#(
    parameter int N_INIT = 249
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  div_t data_i,
    output div_t n_o,
    output logic err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            n_o   <= div_t'(N_INIT);
            err_o <= 1'b0;
        end else if (wr_i) begin
            if (n_legal(data_i)) n_o   <= data_i;
            else                 err_o <= 1'b1;
        end
    end

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_bad_write_held_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !n_legal(data_i)) |=> $stable(n_o));

    p_n_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        (n_o >= div_t'(N_LO)) && (n_o <= div_t'(N_HI)));
endmodule

// File: rtl/refdiv_8k.sv
`timescale 1ns/1ps
module refdiv_8k
    import refdiv_pkg::*;
#(
    parameter int NUM_REF = 2,
    parameter int SYNC    = 2,
    parameter int N_INIT  = 249
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_REF-1:0]      ref_in,
    input  logic [NUM_REF-1:0][7:0] mode_in,
    input  logic                    n_wr,
    input  logic [DIV_W-1:0]        n_wdata,
    input  logic                    fall_edge,
    output logic [NUM_REF-1:0]      tick_8k,
    output logic                    n_err
);
    div_t n_cur;

    refdiv_nreg #(.N_INIT(N_INIT)) u_nreg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (n_wr),
        .data_i (n_wdata),
        .n_o    (n_cur),
        .err_o  (n_err)
    );

    for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
        logic  evt;
        div_t  div_req;
        mode_t mode;

        assign mode    = mode_t'(mode_in[g]);
        assign div_req = pick_div(mode, n_cur);

        refdiv_edge #(.SYNC(SYNC)) u_edge (
            .clk      (clk),
            .rst      (rst),
            .ref_i    (ref_in[g]),
            .fall_sel (fall_edge),
            .evt_o    (evt)
        );

        refdiv_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .evt_i     (evt),
            .div_req_i (div_req),
            .tick_o    (tick_8k[g])
        );

        p_manual_wins_r5: assert property (@(posedge clk) disable iff (rst)
            mode.manual |-> (div_req == n_cur + div_t'(1)));
    end
endmodule

// File: tb/test_refdiv_8k.sv
`timescale 1ns/1ps
module test_refdiv_8k;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      ref_in = 2'b00;
    logic [1:0][7:0] mode_in = '0;
    logic            n_wr = 1'b0;
    logic [13:0]     n_wdata = '0;
    logic            fall_edge = 1'b0;
    logic [1:0]      tick_8k;
    logic            n_err;

    int n_chk = 0;
    int n_bad = 0;
    int pc0 = 0;
    int pc1 = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    refdiv_8k i_refdiv_8k (
        .clk(clk), .rst(rst), .ref_in(ref_in), .mode_in(mode_in),
        .n_wr(n_wr), .n_wdata(n_wdata), .fall_edge(fall_edge),
        .tick_8k(tick_8k), .n_err(n_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // count strobes and check reference level while a strobe is high (R6)
    always @(negedge clk) begin
        if (!rst) begin
            if (tick_8k[0]) begin
                pc0++;
                chk("R6 level at strobe ch0", int'(ref_in[0]), int'(!fall_edge));
            end
            if (tick_8k[1]) begin
                pc1++;
                chk("R6 level at strobe ch1", int'(ref_in[1]), int'(!fall_edge));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_in = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        pc0 = 0;
        pc1 = 0;
    endtask

    task automatic write_n(input int v);
        @(negedge clk);
        n_wr = 1'b1;
        n_wdata = 14'(v);
        @(negedge clk);
        n_wr = 1'b0;
    endtask

    task automatic run_periods(input int k);
        for (int i = 0; i < k; i++) begin
            ref_in = 2'b11;
            repeat (4) @(negedge clk);
            ref_in = 2'b00;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state and default N
        mode_in[0] = 8'h80;
        mode_in[1] = 8'h00;
        do_reset();
        @(negedge clk);
        chk("R8 tick after reset", int'(tick_8k), 0);
        chk("R8 err after reset", int'(n_err), 0);
        run_periods(249);
        chk("R8 default N no early strobe", pc0, 0);
        run_periods(1);
        chk("R8 default N divides by 250", pc0, 1);
        chk("R4 pass-through ch1", pc1, 250);

        // R1, R9, R6: sweep N and both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int n = 1; n <= 12; n++) begin
                fall_edge = pol[0];
                mode_in[0] = 8'h80;
                mode_in[1] = 8'h00;
                do_reset();
                write_n(n);
                run_periods(3 * (n + 1) + 1);
                chk("R1 manual divide ch0", pc0, 3);
                chk("R9 independent ch1", pc1, 3 * (n + 1) + 1);
            end
        end
        fall_edge = 1'b0;

        // R3 spot rates on ch0, R5 manual priority with bucket bits on ch1
        for (int code = 1; code <= 4; code++) begin
            int d;
            d = (code == 1) ? 193 : (code == 2) ? 256 : (code == 3) ? 810 : 2430;
            mode_in[0] = 8'h40 | 8'(code);
            mode_in[1] = 8'hF0 | 8'(code);
            do_reset();
            write_n(6);
            run_periods(d - 1);
            chk("R3 no strobe before spot count", pc0, 0);
            run_periods(4);
            chk("R3 spot divide", pc0, 1);
            chk("R5 manual wins, bucket ignored", pc1, (d + 3) / 7);
        end

        // R4: unsupported spot code passes through; R5 bucket bits on pass-through
        mode_in[0] = 8'h40;
        mode_in[1] = 8'h79;
        do_reset();
        run_periods(5);
        chk("R4 spot code 0 passes", pc0, 5);
        chk("R4 spot code 9 passes", pc1, 5);
        mode_in[0] = 8'h30;
        mode_in[1] = 8'hB0;
        do_reset();
        write_n(2);
        run_periods(6);
        chk("R5 bucket only passes", pc0, 6);
        chk("R5 bucket with manual", pc1, 2);

        // R2: illegal writes
        mode_in[0] = 8'h80;
        mode_in[1] = 8'h00;
        do_reset();
        write_n(4);
        @(negedge clk);
        chk("R2 legal write no err", int'(n_err), 0);
        write_n(0);
        @(negedge clk);
        chk("R2 zero sets err", int'(n_err), 1);
        write_n(12500);
        run_periods(11);
        chk("R2 N kept after bad writes", pc0, 2);
        write_n(12499);
        write_n(9);
        @(negedge clk);
        chk("R2 err sticky", int'(n_err), 1);
        pc0 = 0;
        run_periods(21);
        chk("R2 later legal write accepted", pc0, 2);
        do_reset();
        @(negedge clk);
        chk("R8 reset clears err", int'(n_err), 0);

        // R7: change of N in mid-period
        mode_in[0] = 8'h80;
        do_reset();
        write_n(9);
        run_periods(3);
        write_n(2);
        run_periods(6);
        chk("R7 old period not cut short", pc0, 0);
        run_periods(1);
        chk("R7 old period completes", pc0, 1);
        run_periods(6);
        chk("R7 new divisor next period", pc0, 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule